// File: doc/BRIEF.md
# SYSREF-Aligned Multiframe Clock Counter

This block produces the local multiframe timing reference for a deterministic-latency serial converter link. It runs in the link-clock domain, where each clock carries four octets. A free-running counter marks the multiframe period, which is 32 frames of F octets. The block brings the external SYSREF reference into the clock domain, finds its rising edges, and restarts the counter on such an edge. The counter phase therefore follows SYSREF and stays the same across resets.

There are two detection modes. In continuous mode every SYSREF rising edge realigns the counter. An edge that arrives anywhere other than on a multiframe boundary also sets a sticky phase-error flag. In single-shot mode, software first arms a detect flag. Only the first rising edge after arming realigns the counter, and that edge clears the flag. Later periodic pulses leave the phase untouched. On every realigning edge the block also captures the counter value it had at that moment, as an 8-bit delay count. Software can compare this value across resets to confirm that alignment repeats.

Top module: `mfclk_align`

## Requirements
- R1: SYSREF passes through two synchronizing flip-flops. A 0-to-1 transition of the synchronized level counts as a rising edge. A rise of `sysref_in` that meets the third clock edge after it realigns the counter, so `mf_count` reads 0 after that edge. A level that stays high produces no further edges.
- R2: Without realignment, `mf_count` counts 0, 1, … up to 8·F−1 and wraps to 0. F is selected by `frame_oct_sel`: 0 gives F=1, 1 gives F=2, 2 gives F=4 and 3 gives F=8. The resulting periods are 8, 16, 32 and 64 clocks.
- R3: `mf_start` is high exactly in the cycles where `mf_count` is 0.
- R4: With `single_mode`=0, every detected rising edge loads the counter with 0 at the edge where it is detected.
- R5: In continuous mode, a detected edge found while the counter holds its last value (8·F−1) is on the boundary and leaves `phase_err` unchanged. Any other detected edge sets `phase_err`, which then stays at 1 until an `arm` pulse. Set takes priority over clear.
- R6: With `single_mode`=1, a detected edge realigns the counter only while `armed` is 1. Edges seen while `armed` is 0 are ignored: the count keeps running, and neither `phase_err` nor `rel_dly` changes.
- R7: An `arm` pulse sets `armed` to 1 on the next clock edge. In either mode, any detected rising edge without `arm` clears `armed` to 0.
- R8: On every edge that realigns the counter, `rel_dly` captures the zero-extended value `mf_count` had just before the load.
- R9: After synchronous reset (`rst`=1), `mf_count`, `armed`, `phase_err` and `rel_dly` are all 0.
- R10: If `frame_oct_sel` changes so that the count is at or beyond the new last value, the counter wraps to 0 on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst | input | 1 | Synchronous active-high reset |
| sysref_in | input | 1 | Asynchronous SYSREF reference |
| frame_oct_sel | input | 2 | Octets per frame select (0..3 gives F = 1, 2, 4, 8) |
| single_mode | input | 1 | 1: single-shot detect, 0: continuous detect |
| arm | input | 1 | Pulse: arm single detect and clear the phase error |
| mf_count | output | 6 | Current multiframe count |
| mf_start | output | 1 | High on the first clock of each multiframe |
| armed | output | 1 | Single-detect status, reads 0 once an edge is seen |
| phase_err | output | 1 | Sticky flag for an off-boundary SYSREF edge |
| rel_dly | output | 8 | Count captured at the last realigning edge |

## Verification
A SYSREF rise lands in the count, the error flag, the armed flag and the delay count on the third clock edge after it. An `arm` pulse or a change of `frame_oct_sel` acts on the very next edge, and `mf_start` follows the count with no extra delay. The bench drives inputs just after a falling edge and compares all outputs against its behavioural model at every falling edge. The directed boundary checks are placed exactly three edges after a SYSREF rise, with the rise timed from the model's count so that the detection falls either on or off the boundary as intended.

// File: rtl/mfclk_pkg.sv
package mfclk_pkg;

    typedef enum logic [1:0] {
        OCT_1 = 2'd0,
        OCT_2 = 2'd1,
        OCT_4 = 2'd2,
        OCT_8 = 2'd3
    } frame_oct_e;

    typedef enum logic {
        DET_CONT   = 1'b0,
        DET_SINGLE = 1'b1
    } det_mode_e;

    typedef struct packed {
        logic armed;
        logic phase_err;
    } align_stat_t;

    // Last count of a multiframe: K frames * F octets / octets per clock - 1
    function automatic int unsigned mf_last(frame_oct_e sel,
                                            int unsigned k_frames,
                                            int unsigned oct_per_clk);
        int unsigned per;
        case (sel)
            OCT_1:   per = (k_frames * 1) / oct_per_clk;
            OCT_2:   per = (k_frames * 2) / oct_per_clk;
            OCT_4:   per = (k_frames * 4) / oct_per_clk;
            default: per = (k_frames * 8) / oct_per_clk;
        endcase
        return per - 1;
    endfunction

endpackage

// File: rtl/mfclk_sysref_sync.sv
module mfclk_sysref_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sysref_in,
    output logic rise
);
    logic [STAGES-1:0] chain;
    logic              prev;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= sysref_in;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], sysref_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= chain[STAGES-1];
    end

    assign rise = chain[STAGES-1] & ~prev;

    // R1: a rising edge is a single-cycle event
    p_rise_single_r1: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/mfclk_counter.sv
module mfclk_counter
    import mfclk_pkg::*;
#(
    parameter int unsigned CNT_W          = 6,
    parameter int unsigned K_FRAMES       = 32,
    parameter int unsigned OCTETS_PER_CLK = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  frame_oct_e       fsel,
    input  logic             load,
    output logic [CNT_W-1:0] cnt,
    output logic             at_last,
    output logic             mf_start
);
    logic [CNT_W-1:0] last_v;

    assign last_v   = CNT_W'(mf_last(fsel, K_FRAMES, OCTETS_PER_CLK));
    assign at_last  = (cnt >= last_v);
    assign mf_start = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (load)    cnt <= '0;
        else if (at_last) cnt <= '0;
        else              cnt <= cnt + CNT_W'(1);
    end

    // R4: a realign loads zero
    p_load_zero_r4: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt == '0));
    // R2: free counting steps by one below the last value
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt < last_v) |=> (cnt == $past(cnt) + CNT_W'(1)));
    // R10: at or beyond the last value the count wraps
    p_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt >= last_v) |=> (cnt == '0));

endmodule

// File: rtl/mfclk_align_ctrl.sv
module mfclk_align_ctrl
    import mfclk_pkg::*;
#(
    parameter int unsigned CNT_W = 6,
    parameter int unsigned DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  det_mode_e        mode,
    input  logic             arm,
    input  logic [CNT_W-1:0] cnt,
    input  logic             at_last,
    output logic             load,
    output align_stat_t      stat,
    output logic [DLY_W-1:0] dly
);
    logic off_bound;

    assign load      = rise & ((mode == DET_CONT) | stat.armed);
    assign off_bound = rise & (mode == DET_CONT) & ~at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat <= '0;
            dly  <= '0;
        end else begin
            if (load) dly <= DLY_W'(cnt);
            if (arm)       stat.armed <= 1'b1;
            else if (rise) stat.armed <= 1'b0;
            if (off_bound) stat.phase_err <= 1'b1;
            else if (arm)  stat.phase_err <= 1'b0;
        end
    end

    // R7: arming takes effect on the next edge
    p_arm_sets_r7: assert property (@(posedge clk) disable iff (rst)
        arm |=> stat.armed);
    // R7: a detected edge disarms
    p_edge_disarms_r7: assert property (@(posedge clk) disable iff (rst)
        (rise && !arm) |=> !stat.armed);
    // R6: unarmed single mode never realigns
    p_single_ignore_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == DET_SINGLE && !stat.armed) |-> !load);
    // R5: the error flag is sticky until arm
    p_err_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (stat.phase_err && !arm) |=> stat.phase_err);
    // R5: a boundary-aligned state raises no error
    p_on_bound_r5: assert property (@(posedge clk) disable iff (rst)
        (!stat.phase_err && at_last) |=> !stat.phase_err);
    // R8: the delay count holds the pre-load count
    p_snap_r8: assert property (@(posedge clk) disable iff (rst)
        load |=> (dly == DLY_W'($past(cnt))));

endmodule

// File: rtl/mfclk_align.sv
module mfclk_align
    import mfclk_pkg::*;
#(
    parameter int unsigned K_FRAMES       = 32,
    parameter int unsigned OCTETS_PER_CLK = 4,
    parameter int unsigned MAX_F          = 8,
    parameter int unsigned SYNC_STAGES    = 2,
    parameter int unsigned DLY_W          = 8,
    localparam int unsigned CNT_W         = $clog2(K_FRAMES * MAX_F / OCTETS_PER_CLK)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sysref_in,
    input  logic [1:0]       frame_oct_sel,
    input  logic             single_mode,
    input  logic             arm,
    output logic [CNT_W-1:0] mf_count,
    output logic             mf_start,
    output logic             armed,
    output logic             phase_err,
    output logic [DLY_W-1:0] rel_dly
);
    logic        rise;
    logic        load;
    logic        at_last;
    align_stat_t stat;
    frame_oct_e  fsel;
    det_mode_e   mode;

    assign fsel = frame_oct_e'(frame_oct_sel);
    assign mode = det_mode_e'(single_mode);

    mfclk_sysref_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst       (rst),
        .sysref_in (sysref_in),
        .rise      (rise)
    );

    mfclk_counter #(
        .CNT_W          (CNT_W),
        .K_FRAMES       (K_FRAMES),
        .OCTETS_PER_CLK (OCTETS_PER_CLK)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .fsel     (fsel),
        .load     (load),
        .cnt      (mf_count),
        .at_last  (at_last),
        .mf_start (mf_start)
    );

    mfclk_align_ctrl #(
        .CNT_W (CNT_W),
        .DLY_W (DLY_W)
    ) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .rise    (rise),
        .mode    (mode),
        .arm     (arm),
        .cnt     (mf_count),
        .at_last (at_last),
        .load    (load),
        .stat    (stat),
        .dly     (rel_dly)
    );

    assign armed     = stat.armed;
    assign phase_err = stat.phase_err;

    // R3: boundary strobe coincides with a zero count
    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(mf_start) |-> (mf_count == '0));

endmodule

// File: tb/mfclk_align_tb.sv
`timescale 1ns/1ps
module mfclk_align_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sysref_in = 1'b0;
    logic [1:0] frame_oct_sel = 2'd0;
    logic       single_mode = 1'b0;
    logic       arm = 1'b0;
    logic [5:0] mf_count;
    logic       mf_start;
    logic       armed;
    logic       phase_err;
    logic [7:0] rel_dly;

    always #2.5 clk = ~clk;

    mfclk_align u_dut (
        .clk           (clk),
        .rst           (rst),
        .sysref_in     (sysref_in),
        .frame_oct_sel (frame_oct_sel),
        .single_mode   (single_mode),
        .arm           (arm),
        .mf_count      (mf_count),
        .mf_start      (mf_start),
        .armed         (armed),
        .phase_err     (phase_err),
        .rel_dly       (rel_dly)
    );

    int    n_chk = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string ph = "R2";

    // behavioural reference model
    int m_cnt = 0, m_armed = 0, m_err = 0, m_dly = 0;
    bit hist[$] = '{0, 0, 0};

    always @(posedge clk) begin : model
        int  last;
        bit  edge_seen, take;
        if (rst) begin
            m_cnt = 0; m_armed = 0; m_err = 0; m_dly = 0;
            hist = '{0, 0, 0};
        end else begin
            last = (32 * (1 << frame_oct_sel)) / 4 - 1;
            edge_seen = hist[1] && !hist[2];
            take = edge_seen && (!single_mode || m_armed != 0);
            if (take) m_dly = m_cnt;
            if (edge_seen && !single_mode && m_cnt < last) m_err = 1;
            else if (arm) m_err = 0;
            if (arm) m_armed = 1;
            else if (edge_seen) m_armed = 0;
            if (take || m_cnt >= last) m_cnt = 0;
            else m_cnt = m_cnt + 1;
            hist.push_front(sysref_in);
            void'(hist.pop_back());
        end
    end

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (!rst) begin
                chk(ph,   "count",     int'(mf_count),  m_cnt);
                chk("R3", "mf_start",  int'(mf_start),  int'(m_cnt == 0));
                chk("R7", "armed",     int'(armed),     m_armed);
                chk("R5", "phase_err", int'(phase_err), m_err);
                chk("R8", "rel_dly",   int'(rel_dly),   m_dly);
            end
        end
    endtask

    task automatic wait_cnt(int v);
        for (int i = 0; i < 200 && m_cnt != v; i++) tick(1);
    endtask

    task automatic arm_pulse();
        arm = 1'b1; tick(1); arm = 1'b0;
    endtask

    initial begin : watchdog
        #(200000 * 5.0);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9", "count",     int'(mf_count),  0);
        chk("R9", "armed",     int'(armed),     0);
        chk("R9", "phase_err", int'(phase_err), 0);
        chk("R9", "rel_dly",   int'(rel_dly),   0);
        rst = 1'b0;
        ph = "R2"; tick(20);

        // R1 / R4: off-boundary edge, detection at count 4
        ph = "R4"; wait_cnt(2);
        sysref_in = 1'b1; tick(3);
        chk("R1", "count three edges after rise", int'(mf_count), 0);
        chk("R5", "off-boundary error",           int'(phase_err), 1);
        chk("R8", "captured count",               int'(rel_dly), 4);
        tick(5); sysref_in = 1'b0; tick(3);

        // R7 arm clears error
        arm_pulse();
        chk("R7", "armed after arm", int'(armed), 1);
        chk("R5", "error cleared by arm", int'(phase_err), 0);

        // R5 on-boundary edge: detection at count 7
        ph = "R5"; wait_cnt(5);
        sysref_in = 1'b1; tick(3);
        chk("R5", "on-boundary no error", int'(phase_err), 0);
        chk("R7", "armed cleared by edge", int'(armed), 0);
        chk("R8", "captured boundary count", int'(rel_dly), 7);
        sysref_in = 1'b0; tick(3);

        // R6 single mode, unarmed edge ignored
        ph = "R6"; single_mode = 1'b1; wait_cnt(1);
        sysref_in = 1'b1; tick(3);
        chk("R6", "unarmed edge ignored", int'(mf_count), 4);
        chk("R6", "delay count kept",     int'(rel_dly), 7);
        sysref_in = 1'b0; tick(3);
        arm_pulse();
        wait_cnt(1);
        sysref_in = 1'b1; tick(3);
        chk("R6", "armed edge realigns", int'(mf_count), 0);
        chk("R7", "single detect status", int'(armed), 0);
        chk("R6", "single no error", int'(phase_err), 0);
        sysref_in = 1'b0; tick(3);
        wait_cnt(1);
        sysref_in = 1'b1; tick(3);
        chk("R6", "second edge ignored", int'(mf_count), 4);
        sysref_in = 1'b0; tick(3);

        // R10 runtime F change
        ph = "R10"; single_mode = 1'b0; frame_oct_sel = 2'd3;
        wait_cnt(40);
        frame_oct_sel = 2'd0; tick(1);
        chk("R10", "wrap after shrink", int'(mf_count), 0);
        tick(10);

        // R2 other periods
        ph = "R2"; frame_oct_sel = 2'd1; tick(40);
        frame_oct_sel = 2'd2; tick(70);

        // R5 periodic SYSREF every 64 clocks with period 32
        ph = "R4";
        for (int p = 0; p < 5; p++) begin
            sysref_in = 1'b1; tick(4); sysref_in = 1'b0;
            if (p == 0) begin arm_pulse(); tick(59); end
            else tick(60);
        end
        chk("R5", "periodic aligned no error", int'(phase_err), 0);
        tick(10);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule